// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block picks the divider settings of a pixel-clock synthesizer. After a start pulse that supplies a target dot-clock frequency and the reference frequency, both in hertz, it steps through every combination of the input divider N and the feedback dividers M1 and M2, together with the post-divider P1. The second post-divider P2 is held constant. Every combination is first screened against limits on each field and on the derived quantities. A combination that passes the screen and whose dot clock is not below the target is then scored with a sequential restoring divider.

The search ends early at the first combination that hits the target exactly. If none does, the result is the combination that lands strictly above the target with the smallest error. When the search ends, `done` pulses once, `valid` shows whether any combination qualified, and the divider fields hold the result until the next search finishes.

Top module: `pll_div_search`

## Requirements
- R1: While reset is held and after it is released, `done` and `valid` are 0 until a search has completed.
- R2: A returned result always has N in 3..8, M1 in 10..20, M2 in 5..9, P1 in 1..8 and M1 > M2. `p2_out` always reads 10.
- R3: A combination is accepted only when M = 5·(M1+2) + (M2+2) lies in 70..120 and P = P1·P2 lies in 5..80.
- R4: A combination is accepted only when VCO = floor(ref·M/(N+2)) lies in 1.4e9..2.8e9 Hz and dot = floor(VCO/P) lies in 20e6..400e6 Hz. If no combination qualifies, `valid` is 0 after `done`.
- R5: Combinations are visited in a fixed order: N rising in the outermost loop, then M1 falling, then M2 falling, then P1 falling in the innermost loop.
- R6: The first accepted combination, in visit order, whose dot clock equals the target ends the search and is returned.
- R7: With no exact hit, the result is the accepted combination with dot > target and the smallest dot − target. The error must also be below 0xFFFFFFFF. On a tie the earlier combination wins.
- R8: `done` is high for exactly one cycle per search. `valid` and the divider fields change only in that cycle and hold afterwards.
- R9: A `start` that arrives while a search is running is ignored and does not change that search's result.
- R10: A `start` given in the same cycle that `done` is high begins a new search with the new inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a search when the engine is idle |
| target_hz | input | 32 | Wanted dot-clock frequency in Hz, captured at start |
| ref_hz | input | 32 | Reference frequency in Hz, captured at start |
| done | output | 1 | One-cycle pulse at the end of a search |
| valid | output | 1 | A qualifying combination was found |
| n_out | output | 4 | Chosen N |
| m1_out | output | 5 | Chosen M1 |
| m2_out | output | 4 | Chosen M2 |
| p1_out | output | 4 | Chosen P1 |
| p2_out | output | 4 | Fixed P2 (10) |

## Verification
Two functions can fall in the same cycle: the end-of-search pulse and the acceptance of a new start. The bench raises `start` with fresh inputs exactly in the cycle where it sees `done`. It then judges two things: that the first result was not disturbed, and that a second `done` later delivers the answer its own arithmetic model computes for the new inputs. A second overlap, a start arriving while the divider is busy, is provoked mid-search, and the bench checks that the result still matches the model for the original inputs.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int NW  = 4;
  localparam int M1W = 5;
  localparam int M2W = 4;
  localparam int P1W = 4;
  localparam int P2W = 4;

  typedef struct packed {
    logic [NW-1:0]  n;
    logic [M1W-1:0] m1;
    logic [M2W-1:0] m2;
    logic [P1W-1:0] p1;
  } cand_t;

  typedef enum logic [1:0] {S_IDLE, S_SCREEN, S_DIV, S_FIN} phase_t;

  function automatic logic [63:0] comb_m(cand_t c);
    return 64'd5 * (64'(c.m1) + 64'd2) + (64'(c.m2) + 64'd2);
  endfunction

  function automatic logic [63:0] comb_p(cand_t c, logic [63:0] p2);
    return 64'(c.p1) * p2;
  endfunction

  function automatic logic [63:0] ref_div(cand_t c);
    return 64'(c.n) + 64'd2;
  endfunction

  function automatic logic in_rng(logic [63:0] v, logic [63:0] lo, logic [63:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/pll_cand_walker.sv
module pll_cand_walker
  import pll_search_pkg::*;
#(
  parameter int N_MIN  = 3,
  parameter int N_MAX  = 8,
  parameter int M1_MIN = 10,
  parameter int M1_MAX = 20,
  parameter int M2_MIN = 5,
  parameter int M2_MAX = 9,
  parameter int P1_MIN = 1,
  parameter int P1_MAX = 8
)(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  output cand_t cand,
  output logic  last
);
  localparam logic [NW-1:0]  NMIN_L  = NW'(N_MIN);
  localparam logic [NW-1:0]  NMAX_L  = NW'(N_MAX);
  localparam logic [M1W-1:0] M1MIN_L = M1W'(M1_MIN);
  localparam logic [M1W-1:0] M1MAX_L = M1W'(M1_MAX);
  localparam logic [M2W-1:0] M2MIN_L = M2W'(M2_MIN);
  localparam logic [M2W-1:0] M2MAX_L = M2W'(M2_MAX);
  localparam logic [P1W-1:0] P1MIN_L = P1W'(P1_MIN);
  localparam logic [P1W-1:0] P1MAX_L = P1W'(P1_MAX);

  localparam cand_t FIRST = '{n: NMIN_L, m1: M1MAX_L, m2: M2MAX_L, p1: P1MAX_L};
  localparam cand_t FINAL = '{n: NMAX_L, m1: M1MIN_L, m2: M2MIN_L, p1: P1MIN_L};

  assign last = (cand == FINAL);

  // innermost digit is P1 (falling), then M2 (falling), M1 (falling), N (rising)
  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      cand <= FIRST;
    end else if (step) begin
      if (cand.p1 > P1MIN_L) begin
        cand.p1 <= cand.p1 - 1'b1;
      end else begin
        cand.p1 <= P1MAX_L;
        if (cand.m2 > M2MIN_L) begin
          cand.m2 <= cand.m2 - 1'b1;
        end else begin
          cand.m2 <= M2MAX_L;
          if (cand.m1 > M1MIN_L) begin
            cand.m1 <= cand.m1 - 1'b1;
          end else begin
            cand.m1 <= M1MAX_L;
            cand.n  <= cand.n + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pll_cand_screen.sv
module pll_cand_screen
  import pll_search_pkg::*;
#(
  parameter int REF_W  = 32,
  parameter int TGT_W  = 32,
  parameter int XW     = 39,
  parameter int DW     = 10,
  parameter int N_MIN  = 3,
  parameter int N_MAX  = 8,
  parameter int M1_MIN = 10,
  parameter int M1_MAX = 20,
  parameter int M2_MIN = 5,
  parameter int M2_MAX = 9,
  parameter int P1_MIN = 1,
  parameter int P1_MAX = 8,
  parameter int P2_FIX = 10,
  parameter int M_MIN  = 70,
  parameter int M_MAX  = 120,
  parameter int P_MIN  = 5,
  parameter int P_MAX  = 80,
  parameter logic [63:0] DOT_MIN = 64'd20_000_000,
  parameter logic [63:0] DOT_MAX = 64'd400_000_000,
  parameter logic [63:0] VCO_MIN = 64'd1_400_000_000,
  parameter logic [63:0] VCO_MAX = 64'd2_800_000_000
)(
  input  cand_t             cand,
  input  logic [REF_W-1:0]  ref_hz,
  input  logic [TGT_W-1:0]  tgt_hz,
  output logic              fits,
  output logic              below,
  output logic [XW-1:0]     dividend,
  output logic [DW-1:0]     divisor
);
  logic [63:0] m_w, p_w, nd_w, x_w, d_w;
  logic        field_ok, derived_ok, vco_ok, dot_ok;

  always_comb begin
    m_w  = comb_m(cand);
    p_w  = comb_p(cand, 64'(P2_FIX));
    nd_w = ref_div(cand);
    x_w  = 64'(ref_hz) * m_w;
    d_w  = nd_w * p_w;
    field_ok = in_rng(64'(cand.n),  64'(N_MIN),  64'(N_MAX))  &&
               in_rng(64'(cand.m1), 64'(M1_MIN), 64'(M1_MAX)) &&
               in_rng(64'(cand.m2), 64'(M2_MIN), 64'(M2_MAX)) &&
               in_rng(64'(cand.p1), 64'(P1_MIN), 64'(P1_MAX)) &&
               (64'(cand.m1) > 64'(cand.m2));
    derived_ok = in_rng(m_w, 64'(M_MIN), 64'(M_MAX)) &&
                 in_rng(p_w, 64'(P_MIN), 64'(P_MAX));
    // floor(x/q) in [lo,hi]  <=>  lo*q <= x < (hi+1)*q
    vco_ok = (x_w >= VCO_MIN * nd_w) && (x_w < (VCO_MAX + 64'd1) * nd_w);
    dot_ok = (x_w >= DOT_MIN * d_w)  && (x_w < (DOT_MAX + 64'd1) * d_w);
    fits   = field_ok && derived_ok && vco_ok && dot_ok;
    below  = x_w < 64'(tgt_hz) * d_w;
    dividend = x_w[XW-1:0];
    divisor  = d_w[DW-1:0];
  end
endmodule

// File: rtl/pll_restore_div.sv
module pll_restore_div #(
  parameter int WN = 39,
  parameter int WS = 10
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [WN-1:0] dividend,
  input  logic [WS-1:0] divisor,
  output logic          busy,
  output logic          fin,
  output logic [WN-1:0] quot
);
  localparam int CW = $clog2(WN + 1);

  logic [WS-1:0] rem_q, dvs_q;
  logic [WN-1:0] acc_q;
  logic [CW-1:0] cnt_q;
  logic [WS:0]   rem_sh, rem_sub;
  logic          ge;

  assign rem_sh  = {rem_q, acc_q[WN-1]};
  assign rem_sub = rem_sh - {1'b0, dvs_q};
  assign ge      = rem_sh >= {1'b0, dvs_q};
  assign quot    = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      acc_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else if (go && !busy) begin
      rem_q <= '0;
      dvs_q <= divisor;
      acc_q <= dividend;
      cnt_q <= CW'(WN);
      busy  <= 1'b1;
      fin   <= 1'b0;
    end else if (busy) begin
      rem_q <= ge ? rem_sub[WS-1:0] : rem_sh[WS-1:0];
      acc_q <= {acc_q[WN-2:0], ge};
      cnt_q <= cnt_q - 1'b1;
      busy  <= (cnt_q != CW'(1));
      fin   <= (cnt_q == CW'(1));
    end else begin
      fin   <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int REF_W  = 32,
  parameter int TGT_W  = 32,
  parameter int ERR_W  = 32,
  parameter int N_MIN  = 3,
  parameter int N_MAX  = 8,
  parameter int M1_MIN = 10,
  parameter int M1_MAX = 20,
  parameter int M2_MIN = 5,
  parameter int M2_MAX = 9,
  parameter int P1_MIN = 1,
  parameter int P1_MAX = 8,
  parameter int P2_FIX = 10,
  parameter int M_MIN  = 70,
  parameter int M_MAX  = 120,
  parameter int P_MIN  = 5,
  parameter int P_MAX  = 80,
  parameter logic [63:0] DOT_MIN = 64'd20_000_000,
  parameter logic [63:0] DOT_MAX = 64'd400_000_000,
  parameter logic [63:0] VCO_MIN = 64'd1_400_000_000,
  parameter logic [63:0] VCO_MAX = 64'd2_800_000_000
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TGT_W-1:0] target_hz,
  input  logic [REF_W-1:0] ref_hz,
  output logic             done,
  output logic             valid,
  output logic [NW-1:0]    n_out,
  output logic [M1W-1:0]   m1_out,
  output logic [M2W-1:0]   m2_out,
  output logic [P1W-1:0]   p1_out,
  output logic [P2W-1:0]   p2_out
);
  localparam int MW = $clog2(5 * (M1_MAX + 2) + M2_MAX + 3);
  localparam int XW = REF_W + MW;
  localparam int DW = $clog2((N_MAX + 2) * P1_MAX * P2_FIX + 1);

  phase_t           st_q, st_d;
  logic [TGT_W-1:0] tgt_q;
  logic [REF_W-1:0] ref_q;
  cand_t            cand, best_q;
  logic [ERR_W-1:0] best_err_q;
  logic             found_q;

  // named events for the checker
  logic busy, load, step, last, fits, below, div_go, div_busy, div_fin;
  logic hit, improve, in_div;
  logic [XW-1:0] dividend, quot, diff;
  logic [DW-1:0] divisor;

  assign busy   = (st_q != S_IDLE);
  assign in_div = (st_q == S_DIV);
  assign load   = (st_q == S_IDLE) && start;
  assign div_go = (st_q == S_SCREEN) && fits && !below;
  assign diff   = quot - XW'(tgt_q);
  assign hit    = in_div && div_fin && (quot == XW'(tgt_q));
  assign improve = in_div && div_fin && !hit && (quot > XW'(tgt_q)) &&
                   (diff < XW'(best_err_q));
  assign step   = ((st_q == S_SCREEN) && !div_go && !last) ||
                  (in_div && div_fin && !hit && !last);

  pll_cand_walker #(
    .N_MIN(N_MIN), .N_MAX(N_MAX), .M1_MIN(M1_MIN), .M1_MAX(M1_MAX),
    .M2_MIN(M2_MIN), .M2_MAX(M2_MAX), .P1_MIN(P1_MIN), .P1_MAX(P1_MAX)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .cand(cand), .last(last)
  );

  pll_cand_screen #(
    .REF_W(REF_W), .TGT_W(TGT_W), .XW(XW), .DW(DW),
    .N_MIN(N_MIN), .N_MAX(N_MAX), .M1_MIN(M1_MIN), .M1_MAX(M1_MAX),
    .M2_MIN(M2_MIN), .M2_MAX(M2_MAX), .P1_MIN(P1_MIN), .P1_MAX(P1_MAX),
    .P2_FIX(P2_FIX), .M_MIN(M_MIN), .M_MAX(M_MAX), .P_MIN(P_MIN), .P_MAX(P_MAX),
    .DOT_MIN(DOT_MIN), .DOT_MAX(DOT_MAX), .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX)
  ) u_screen (
    .cand(cand), .ref_hz(ref_q), .tgt_hz(tgt_q), .fits(fits), .below(below),
    .dividend(dividend), .divisor(divisor)
  );

  pll_restore_div #(.WN(XW), .WS(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(dividend), .divisor(divisor),
    .busy(div_busy), .fin(div_fin), .quot(quot)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:   if (start) st_d = S_SCREEN;
      S_SCREEN: if (div_go) st_d = S_DIV;
                else if (last) st_d = S_FIN;
      S_DIV:    if (div_fin) begin
                  if (hit || last) st_d = S_FIN;
                  else             st_d = S_SCREEN;
                end
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      tgt_q      <= '0;
      ref_q      <= '0;
      best_q     <= '0;
      best_err_q <= '1;
      found_q    <= 1'b0;
      done       <= 1'b0;
      valid      <= 1'b0;
      n_out      <= '0;
      m1_out     <= '0;
      m2_out     <= '0;
      p1_out     <= '0;
    end else begin
      st_q <= st_d;
      done <= (st_q == S_FIN);
      if (load) begin
        tgt_q      <= target_hz;
        ref_q      <= ref_hz;
        best_err_q <= '1;
        found_q    <= 1'b0;
      end
      if (hit) begin
        best_q  <= cand;
        found_q <= 1'b1;
      end else if (improve) begin
        best_q     <= cand;
        best_err_q <= diff[ERR_W-1:0];
        found_q    <= 1'b1;
      end
      if (st_q == S_FIN) begin
        valid  <= found_q;
        n_out  <= best_q.n;
        m1_out <= best_q.m1;
        m2_out <= best_q.m2;
        p1_out <= best_q.p1;
      end
    end
  end

  assign p2_out = P2W'(P2_FIX);
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk
  import pll_search_pkg::*;
#(
  parameter int TGT_W  = 32,
  parameter int N_MIN  = 3,
  parameter int N_MAX  = 8,
  parameter int M1_MIN = 10,
  parameter int M1_MAX = 20,
  parameter int M2_MIN = 5,
  parameter int M2_MAX = 9,
  parameter int P1_MIN = 1,
  parameter int P1_MAX = 8,
  parameter int P2_FIX = 10
)(
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             valid,
  input logic             busy,
  input logic             hit,
  input logic             div_fin,
  input logic             in_div,
  input logic [TGT_W-1:0] tgt_q,
  input logic [NW-1:0]    n_out,
  input logic [M1W-1:0]   m1_out,
  input logic [M2W-1:0]   m2_out,
  input logic [P1W-1:0]   p1_out,
  input logic [P2W-1:0]   p2_out
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({valid, n_out, m1_out, m2_out, p1_out}));

  a_r9_target_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tgt_q));

  a_r6_exact_exit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ##2 done);

  a_r4_div_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |-> in_div);

  a_r2_fields_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid) |->
      (32'(n_out)  >= N_MIN)  && (32'(n_out)  <= N_MAX)  &&
      (32'(m1_out) >= M1_MIN) && (32'(m1_out) <= M1_MAX) &&
      (32'(m2_out) >= M2_MIN) && (32'(m2_out) <= M2_MAX) &&
      (32'(p1_out) >= P1_MIN) && (32'(p1_out) <= P1_MAX) &&
      (32'(m1_out) > 32'(m2_out)) && (32'(p2_out) == P2_FIX));
endmodule

bind pll_div_search pll_div_search_chk #(
  .TGT_W(TGT_W), .N_MIN(N_MIN), .N_MAX(N_MAX), .M1_MIN(M1_MIN), .M1_MAX(M1_MAX),
  .M2_MIN(M2_MIN), .M2_MAX(M2_MAX), .P1_MIN(P1_MIN), .P1_MAX(P1_MAX), .P2_FIX(P2_FIX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .valid(valid), .busy(busy), .hit(hit),
  .div_fin(div_fin), .in_div(in_div), .tgt_q(tgt_q), .n_out(n_out),
  .m1_out(m1_out), .m2_out(m2_out), .p1_out(p1_out), .p2_out(p2_out)
);

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
  import pll_search_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] target_hz = '0;
  logic [31:0] ref_hz = '0;
  logic done, valid;
  logic [NW-1:0]  n_out;
  logic [M1W-1:0] m1_out;
  logic [M2W-1:0] m2_out;
  logic [P1W-1:0] p1_out;
  logic [P2W-1:0] p2_out;

  int tests = 0;
  int fails = 0;
  bit closed = 0;

  always #10 clk = ~clk;

  pll_div_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz), .ref_hz(ref_hz),
    .done(done), .valid(valid), .n_out(n_out), .m1_out(m1_out), .m2_out(m2_out),
    .p1_out(p1_out), .p2_out(p2_out)
  );

  // Independent model of the search, written from the requirements (R3..R7)
  function automatic longint unsigned model(input longint unsigned tgt, input longint unsigned rf);
    longint unsigned best_err = 64'hFFFF_FFFF;
    longint unsigned best = 0;
    for (int n = 3; n <= 8; n++)
      for (int m1 = 20; m1 >= 10; m1--)
        for (int m2 = 9; m2 >= 5; m2--)
          for (int p1 = 8; p1 >= 1; p1--) begin
            longint unsigned m, p, vco, dot, err;
            if (m1 <= m2) continue;
            m = 5 * (m1 + 2) + (m2 + 2);
            p = p1 * 10;
            if (m < 70 || m > 120 || p < 5 || p > 80) continue;
            vco = (rf * m) / (n + 2);
            dot = vco / p;
            if (dot < 20_000_000 || dot > 400_000_000) continue;
            if (vco < 64'd1_400_000_000 || vco > 64'd2_800_000_000) continue;
            if (dot == tgt) return (64'd1 << 20) | (longint'(n) << 16) | (longint'(m1) << 8) | (longint'(m2) << 4) | longint'(p1);
            err = (dot > tgt) ? dot - tgt : tgt - dot;
            if (err < best_err && dot > tgt) begin
              best_err = err;
              best = (64'd1 << 20) | (longint'(n) << 16) | (longint'(m1) << 8) | (longint'(m2) << 4) | longint'(p1);
            end
          end
    return best;
  endfunction

  function automatic longint unsigned seen();
    if (!valid) return 0;
    return (64'd1 << 20) | (longint'(n_out) << 16) | (longint'(m1_out) << 8) |
           (longint'(m2_out) << 4) | longint'(p1_out);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic close_run();
    if (!closed) begin
      closed = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic launch(input logic [31:0] t, input logic [31:0] r);
    @(negedge clk);
    start = 1'b1; target_hz = t; ref_hz = r;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (k < 80000) begin
      if (done) return;
      @(negedge clk);
      k++;
    end
    check(1'b0, req, "done timeout", 0, 1);
  endtask

  task automatic run_and_check(input logic [31:0] t, input logic [31:0] r, input string req);
    longint unsigned exp;
    exp = model(t, r);
    launch(t, r);
    wait_done(req);
    check(seen() == exp, req, "result", seen(), exp);
    check(p2_out == 4'd10, "R2", "p2 fixed", p2_out, 10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run not finished", 0, 1);
    close_run();
  end

  initial begin
    longint unsigned exp, hold;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && valid == 1'b0, "R1", "in reset", {done, valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && valid == 1'b0, "R1", "after reset", {done, valid}, 0);

    // R6 R5: exact hits, first in visit order
    run_and_check(32'd28_800_000, 32'd96_000_000, "R6");
    run_and_check(32'd100_000_000, 32'd100_000_000, "R5");
    run_and_check(32'd39_200_000, 32'd96_000_000, "R6");
    // R7 R3: best above target
    run_and_check(32'd108_000_000, 32'd96_000_000, "R7");
    run_and_check(32'd399_000_000, 32'd96_000_000, "R3");
    // R4: nothing above the dot-clock ceiling, and a reference too slow for any VCO
    run_and_check(32'd500_000_000, 32'd96_000_000, "R4");
    run_and_check(32'd50_000_000, 32'd48_000_000, "R4");

    // R8: pulse width and hold
    hold = seen();
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", done, 0);
    repeat (5) @(negedge clk);
    check(seen() == hold, "R8", "result held", seen(), hold);

    // R9: start during a running search is ignored
    exp = model(32'd65_000_000, 32'd96_000_000);
    launch(32'd65_000_000, 32'd96_000_000);
    repeat (60) @(negedge clk);
    start = 1'b1; target_hz = 32'd150_000_000;
    @(negedge clk);
    start = 1'b0;
    wait_done("R9");
    check(seen() == exp, "R9", "busy start ignored", seen(), exp);

    // R10: start in the done cycle begins a new search
    exp = model(32'd399_000_000, 32'd96_000_000);
    launch(32'd399_000_000, 32'd96_000_000);
    wait_done("R10");
    check(seen() == exp, "R10", "first result", seen(), exp);
    start = 1'b1; target_hz = 32'd150_000_000; ref_hz = 32'd96_000_000;
    exp = model(32'd150_000_000, 32'd96_000_000);
    @(negedge clk);
    start = 1'b0;
    wait_done("R10");
    check(seen() == exp, "R10", "restart result", seen(), exp);

    close_run();
  end
endmodule